// File: doc/BRIEF.md
# Interleaved Memory Bank Address Decoder

This block turns a 24-bit byte address into the select lines for a 16-Mbyte memory. The memory is built from thirty-two byte-wide RAM chips of 512 Kbytes each. The chips are paired into sixteen banks, each sixteen bits wide. Within a bank, byte lane 0 holds the even addresses and byte lane 1 holds the odd addresses. For each accepted request the block produces three things: a one-hot bank select, one chip select per byte lane, and the 19-bit address inside the chips. It also flags a word access that is not aligned.

A static mode input chooses where the bank number is taken from. In high-order interleaving, the top four address bits pick the bank, so each bank covers one contiguous megabyte. In low-order interleaving, the four bits just above the lane bit pick the bank, so consecutive words spread across consecutive banks.

A request is a single-cycle strobe with an access-size flag. All outputs are registered and appear exactly one cycle later, qualified by a one-cycle valid pulse. Chip timing, refresh and the data path belong to other blocks.

Top module: `mem_bank_decoder`

## Requirements
- R1: While reset is held and in the first cycle after it, `dec_valid_o`, `misalign_o`, `bank_sel_o`, `lane_cs_o` and `chip_addr_o` are all zero.
- R2: `dec_valid_o` is high in the cycle after each cycle in which `req_valid_i` is high, and low in the cycle after each cycle in which it is low.
- R3: With `map_low_i` = 0 (high-order), a decoded request selects bank `addr[23:20]` (bit n of `bank_sel_o` set for bank n) and drives `chip_addr_o` = `addr[19:1]`.
- R4: With `map_low_i` = 1 (low-order), a decoded request selects bank `addr[4:1]` and drives `chip_addr_o` = `addr[23:5]`. Words at consecutive even addresses therefore land in consecutive banks, wrapping after bank 15.
- R5: A word request (`req_word_i` = 1) at an even address drives `lane_cs_o` = 2'b11. Bit 0 is the even-address lane and bit 1 is the odd-address lane.
- R6: A byte request (`req_word_i` = 0) drives only the lane given by `addr[0]`: 2'b01 for even, 2'b10 for odd. It also drives the bank select.
- R7: A word request at an odd address raises `misalign_o` and drives `lane_cs_o` and `bank_sel_o` to zero. `chip_addr_o` still follows the mapping.
- R8: When `dec_valid_o` is low, `bank_sel_o`, `lane_cs_o` and `misalign_o` are zero. When it is high and `misalign_o` is low, exactly one bit of `bank_sel_o` is set.
- R9: `map_low_i` may change only in a cycle without a request, and the new mapping applies from the next request onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| map_low_i | input | 1 | Interleave mode: 0 high-order, 1 low-order |
| req_valid_i | input | 1 | Request strobe, one request per high cycle |
| req_word_i | input | 1 | Access size: 1 word, 0 byte |
| req_addr_i | input | 24 | Byte address of the request |
| dec_valid_o | output | 1 | Decoded outputs valid (one pulse per request) |
| misalign_o | output | 1 | Word request at an odd address |
| bank_sel_o | output | 16 | One-hot bank select |
| lane_cs_o | output | 2 | Chip select per byte lane (bit 0 even, bit 1 odd) |
| chip_addr_o | output | 19 | Address inside the selected chips |

## Verification
Walking word addresses through both modes shows where the bank field comes from. In low-order mode, consecutive words visit banks 0 to 15 in order. In high-order mode the same addresses stay in bank 0 while the chip address counts up. Byte requests at even and odd addresses, together with word requests at odd addresses, tell the three lane-enable outcomes apart: one lane, both lanes, and none with the error flag. The same fixed address is decoded in both modes, next to a mode change made during an idle cycle. Random addresses, sizes and gaps then check the mapping across all bit positions. The gaps between requests also exercise the quiet-output rule.

// File: rtl/mbd_pkg.sv
package mbd_pkg;

  // Interleave selection as seen by the decode logic
  typedef enum logic {
    MAP_HIGH = 1'b0,
    MAP_LOW  = 1'b1
  } map_mode_e;

  // Byte lanes per word: a 16-bit word spans two byte-wide chips
  localparam int LANES  = 2;
  localparam int LANE_W = 1;

  // Lane enable pattern for a request
  function automatic logic [LANES-1:0] lane_pattern(input logic is_word,
                                                    input logic lsb);
    logic [LANES-1:0] p;
    p = '0;
    if (is_word) begin
      if (!lsb) p = '1;
    end else begin
      p[lsb] = 1'b1;
    end
    return p;
  endfunction

endpackage

// File: rtl/mbd_addr_map.sv
module mbd_addr_map
  import mbd_pkg::*;
#(
  parameter int ADDR_W  = 24,
  parameter int CHIP_AW = 19,
  localparam int BANK_W = ADDR_W - CHIP_AW - LANE_W
) (
  input  logic [ADDR_W-1:0]  addr,
  input  map_mode_e          mode,
  output logic [BANK_W-1:0]  bank,
  output logic [CHIP_AW-1:0] chip_addr
);

  // Field positions for each mapping
  localparam int LO_BANK_LSB = LANE_W;
  localparam int LO_CHIP_LSB = LANE_W + BANK_W;
  localparam int HI_BANK_LSB = LANE_W + CHIP_AW;
  localparam int HI_CHIP_LSB = LANE_W;

  logic [BANK_W-1:0]  bank_hi, bank_lo;
  logic [CHIP_AW-1:0] chip_hi, chip_lo;

  assign bank_hi = addr[HI_BANK_LSB +: BANK_W];
  assign chip_hi = addr[HI_CHIP_LSB +: CHIP_AW];
  assign bank_lo = addr[LO_BANK_LSB +: BANK_W];
  assign chip_lo = addr[LO_CHIP_LSB +: CHIP_AW];

  always_comb begin
    if (mode == MAP_LOW) begin
      bank      = bank_lo;
      chip_addr = chip_lo;
    end else begin
      bank      = bank_hi;
      chip_addr = chip_hi;
    end
  end

endmodule

// File: rtl/mbd_lane_gate.sv
module mbd_lane_gate
  import mbd_pkg::*;
(
  input  logic             valid,
  input  logic             is_word,
  input  logic             lsb,
  output logic [LANES-1:0] lane_en,
  output logic             misalign
);

  logic [LANES-1:0] pattern;

  assign pattern  = lane_pattern(is_word, lsb);
  assign misalign = valid & is_word & lsb;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_en[g] = valid & pattern[g];
  end

endmodule

// File: rtl/mbd_bank_onehot.sv
module mbd_bank_onehot #(
  parameter int BANK_W = 4,
  localparam int BANKS = 1 << BANK_W
) (
  input  logic              en,
  input  logic [BANK_W-1:0] bank,
  output logic [BANKS-1:0]  sel
);

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    assign sel[b] = en && (bank == BANK_W'(b));
  end

endmodule

// File: rtl/mem_bank_decoder.sv
module mem_bank_decoder
  import mbd_pkg::*;
#(
  parameter int ADDR_W  = 24,
  parameter int CHIP_AW = 19,
  localparam int BANK_W = ADDR_W - CHIP_AW - LANE_W,
  localparam int BANKS  = 1 << BANK_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               map_low_i,
  input  logic               req_valid_i,
  input  logic               req_word_i,
  input  logic [ADDR_W-1:0]  req_addr_i,
  output logic               dec_valid_o,
  output logic               misalign_o,
  output logic [BANKS-1:0]   bank_sel_o,
  output logic [LANES-1:0]   lane_cs_o,
  output logic [CHIP_AW-1:0] chip_addr_o
);

  map_mode_e          mode;
  logic [BANK_W-1:0]  bank_idx;
  logic [CHIP_AW-1:0] chip_nxt;
  logic [LANES-1:0]   lane_nxt;
  logic               mis_nxt;
  logic [BANKS-1:0]   sel_nxt;

  assign mode = map_mode_e'(map_low_i);

  mbd_addr_map #(
    .ADDR_W (ADDR_W),
    .CHIP_AW(CHIP_AW)
  ) u_map (
    .addr     (req_addr_i),
    .mode     (mode),
    .bank     (bank_idx),
    .chip_addr(chip_nxt)
  );

  mbd_lane_gate u_lane (
    .valid   (req_valid_i),
    .is_word (req_word_i),
    .lsb     (req_addr_i[0]),
    .lane_en (lane_nxt),
    .misalign(mis_nxt)
  );

  mbd_bank_onehot #(
    .BANK_W(BANK_W)
  ) u_bank (
    .en  (req_valid_i & ~mis_nxt),
    .bank(bank_idx),
    .sel (sel_nxt)
  );

  // Output stage: select lines follow the strobe, chip address holds
  always_ff @(posedge clk) begin
    if (rst) begin
      dec_valid_o <= 1'b0;
      misalign_o  <= 1'b0;
      bank_sel_o  <= '0;
      lane_cs_o   <= '0;
      chip_addr_o <= '0;
    end else begin
      dec_valid_o <= req_valid_i;
      misalign_o  <= mis_nxt;
      bank_sel_o  <= sel_nxt;
      lane_cs_o   <= lane_nxt;
      if (req_valid_i) chip_addr_o <= chip_nxt;
    end
  end

endmodule

// File: rtl/mbd_checker.sv
module mbd_checker
  import mbd_pkg::*;
#(
  parameter int ADDR_W  = 24,
  parameter int CHIP_AW = 19,
  localparam int BANK_W = ADDR_W - CHIP_AW - LANE_W,
  localparam int BANKS  = 1 << BANK_W
) (
  input logic               clk,
  input logic               rst,
  input logic               map_low_i,
  input logic               req_valid_i,
  input logic               req_word_i,
  input logic [ADDR_W-1:0]  req_addr_i,
  input logic               dec_valid_o,
  input logic               misalign_o,
  input logic [BANKS-1:0]   bank_sel_o,
  input logic [LANES-1:0]   lane_cs_o,
  input logic [CHIP_AW-1:0] chip_addr_o
);

  logic [BANK_W-1:0]  a_bank_hi, a_bank_lo;
  logic [CHIP_AW-1:0] a_chip_hi, a_chip_lo;
  logic               a_lsb;

  assign a_bank_hi = req_addr_i[ADDR_W-1 -: BANK_W];
  assign a_bank_lo = req_addr_i[BANK_W:1];
  assign a_chip_hi = req_addr_i[CHIP_AW:1];
  assign a_chip_lo = req_addr_i[ADDR_W-1 -: CHIP_AW];
  assign a_lsb     = req_addr_i[0];

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    $past(rst) |-> (!dec_valid_o && bank_sel_o == '0 && lane_cs_o == '0));

  // R2
  valid_follows_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid_i |=> dec_valid_o);

  // R2
  no_extra_valid_chk: assert property (@(posedge clk) disable iff (rst)
    !req_valid_i |=> !dec_valid_o);

  // R3
  high_map_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid_i && !map_low_i && !(req_word_i && a_lsb) |=>
      (bank_sel_o == (BANKS'(1) << $past(a_bank_hi)) && chip_addr_o == $past(a_chip_hi)));

  // R4
  low_map_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid_i && map_low_i && !(req_word_i && a_lsb) |=>
      (bank_sel_o == (BANKS'(1) << $past(a_bank_lo)) && chip_addr_o == $past(a_chip_lo)));

  // R5
  word_lanes_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid_i && req_word_i && !a_lsb |=> lane_cs_o == 2'b11);

  // R6
  byte_lane_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid_i && !req_word_i |=> lane_cs_o == (2'b01 << $past(a_lsb)));

  // R7
  misalign_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid_i && req_word_i && a_lsb |=>
      (misalign_o && lane_cs_o == '0 && bank_sel_o == '0));

  // R8
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !dec_valid_o |-> (bank_sel_o == '0 && lane_cs_o == '0 && !misalign_o));

  // R8
  bank_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    dec_valid_o && !misalign_o |-> $countones(bank_sel_o) == 1);

  // R9
  mode_hold_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid_i && $past(!rst) |-> $stable(map_low_i));

endmodule

bind mem_bank_decoder mbd_checker #(
  .ADDR_W (ADDR_W),
  .CHIP_AW(CHIP_AW)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .map_low_i  (map_low_i),
  .req_valid_i(req_valid_i),
  .req_word_i (req_word_i),
  .req_addr_i (req_addr_i),
  .dec_valid_o(dec_valid_o),
  .misalign_o (misalign_o),
  .bank_sel_o (bank_sel_o),
  .lane_cs_o  (lane_cs_o),
  .chip_addr_o(chip_addr_o)
);

// File: tb/mem_bank_decoder_test.sv
module mem_bank_decoder_test;

  localparam int AW = 24;
  localparam int CW = 19;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          map_low = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_word = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic          dec_valid;
  logic          misalign;
  logic [15:0]   bank_sel;
  logic [1:0]    lane_cs;
  logic [CW-1:0] chip_addr;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  typedef struct {
    bit          valid;
    bit          mode_low;
    bit          word;
    int unsigned addr;
  } req_t;

  req_t pend_q[$];

  always #5 clk = ~clk;

  mem_bank_decoder uut (
    .clk        (clk),
    .rst        (rst),
    .map_low_i  (map_low),
    .req_valid_i(req_valid),
    .req_word_i (req_word),
    .req_addr_i (req_addr),
    .dec_valid_o(dec_valid),
    .misalign_o (misalign),
    .bank_sel_o (bank_sel),
    .lane_cs_o  (lane_cs),
    .chip_addr_o(chip_addr)
  );

  task automatic chk(input string req, input string what,
                     input longint act, input longint exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // Compare the outputs against the request accepted one edge earlier
  task automatic compare(input req_t r);
    int unsigned bank, chip, lanes, sel;
    bit          odd, mis;
    string       map_tag;
    chk("R2", "dec_valid", dec_valid, r.valid);
    if (!r.valid) begin
      chk("R8", "idle bank_sel", bank_sel, 0);
      chk("R8", "idle lane_cs", lane_cs, 0);
      chk("R8", "idle misalign", misalign, 0);
      return;
    end
    odd = (r.addr % 2) == 1;
    mis = r.word && odd;
    if (r.mode_low) begin
      bank = (r.addr / 2) % 16;
      chip = r.addr / 32;
      map_tag = "R4";
    end else begin
      bank = r.addr / (1 << 20);
      chip = (r.addr % (1 << 20)) / 2;
      map_tag = "R3";
    end
    if (r.word) lanes = odd ? 0 : 3;
    else        lanes = odd ? 2 : 1;
    sel = mis ? 0 : (1 << bank);
    chk(mis ? "R7" : map_tag, "bank_sel", bank_sel, sel);
    chk(map_tag, "chip_addr", chip_addr, chip);
    chk(mis ? "R7" : (r.word ? "R5" : "R6"), "lane_cs", lane_cs, lanes);
    chk("R7", "misalign", misalign, mis);
  endtask

  // One clock: drive at a falling edge, check at the next falling edge
  task automatic step(input bit v, input bit w, input int unsigned a);
    req_t r;
    req_valid = v;
    req_word  = w;
    req_addr  = AW'(a);
    r.valid = v; r.mode_low = map_low; r.word = w; r.addr = a;
    pend_q.push_back(r);
    @(negedge clk);
    compare(pend_q.pop_front());
  endtask

  task automatic set_mode(input bit m);
    step(1'b0, 1'b0, 0);
    map_low = m;
    step(1'b0, 1'b0, 0);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      n_checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin : stim
    @(negedge clk);
    @(negedge clk);
    // R1: outputs quiet under reset
    chk("R1", "reset dec_valid", dec_valid, 0);
    chk("R1", "reset bank_sel", bank_sel, 0);
    chk("R1", "reset lane_cs", lane_cs, 0);
    chk("R1", "reset chip_addr", chip_addr, 0);
    chk("R1", "reset misalign", misalign, 0);
    rst = 1'b0;
    step(1'b0, 1'b0, 0);

    // High-order mode: walking words stay in bank 0 (R3)
    for (int i = 0; i < 8; i++) step(1'b1, 1'b1, 2 * i);
    // Byte lanes and misaligned word (R6, R7)
    step(1'b1, 1'b0, 32'h00_0010);
    step(1'b1, 1'b0, 32'h00_0011);
    step(1'b1, 1'b1, 32'h00_0013);
    step(1'b0, 1'b0, 0);
    step(1'b1, 1'b1, 32'hF0_0002);
    step(1'b1, 1'b0, 32'hFF_FFFF);
    step(1'b1, 1'b1, 32'h00_00B2);

    // R9: mode changed while idle, applies to the very next request
    set_mode(1'b1);
    step(1'b1, 1'b1, 32'h00_00B2);
    chk("R9", "bank after mode switch", bank_sel, 16'h0200);
    chk("R9", "chip after mode switch", chip_addr, 5);

    // Low-order mode: consecutive words walk all banks and wrap (R4)
    for (int i = 0; i < 20; i++) step(1'b1, 1'b1, 32'h12_3400 + 2 * i);
    step(1'b1, 1'b0, 32'hFF_FFFF);
    step(1'b1, 1'b1, 32'h00_0001);
    step(1'b0, 1'b0, 0);

    // Random traffic in both modes with gaps
    for (int m = 0; m < 2; m++) begin
      set_mode(m[0]);
      for (int i = 0; i < 300; i++) begin
        step($urandom_range(0, 3) != 0, $urandom_range(0, 1) == 1,
             $urandom_range(0, 32'hFF_FFFF));
      end
    end
    step(1'b0, 1'b0, 0);

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule